// File: doc/BRIEF.md
# I2C ten-bit slave address matcher

This block decides whether an I2C slave has been selected by a two-byte, ten-bit address. It sits between a bit-level bus engine and the slave's data path. The bus engine hands it decoded events: start, repeated start, stop, and each received byte together with a one-cycle strobe. The block compares these against a configured ten-bit own address. For every address byte it answers with an acknowledge request in the same cycle as the strobe, so the engine can drive the ninth clock without waiting.

The header byte carries a fixed 11110 pattern, the two top address bits and the direction bit. A header that matches and asks for a write only makes the slave tentative, because several slaves can share the same two top bits. The low byte then picks exactly one slave. After a repeated start, a slave that was selected before may take a read header on its own and turn into a transmitter without a second low byte.

Each acknowledged address byte gives an interrupt pulse. A side flag marks the tentative header case, so software does not treat that byte as data.

Top module: `i2c10_addr_match`

## Requirements
- R1: After a start, a byte whose bits [7:1] equal {5'b11110, own_addr_i[9:8]} and whose bit 0 (direction, 0 = write) is 0 drives ack_o high in its strobe cycle. After it, addressed_o stays 0 (the slave is only tentative).
- R2: In the byte after an acknowledged write header, a value equal to own_addr_i[7:0] drives ack_o high in the strobe cycle. From the next cycle addressed_o is 1 and slave_tx_o is 0.
- R3: A header byte that does not match, or a low byte that does not match, gives no acknowledge and leaves addressed_o at 0. Every later byte is then ignored (ack_o low, outputs unchanged) until the next start or repeated start.
- R4: A stop or a start clears addressed_o and slave_tx_o from the next cycle and forgets any earlier selection. Reset does the same.
- R5: After a repeated start, a slave that was addressed before the repeated start acknowledges a matching header with bit 0 = 1 (read). From the next cycle it has addressed_o = 1 and slave_tx_o = 1, with no low byte needed.
- R6: A slave that was not addressed before the latest start or repeated start never acknowledges a header with bit 0 = 1.
- R7: addressed_o stays at 1 across a repeated start until the next address byte arrives. If that byte is not acknowledged, addressed_o falls to 0 the cycle after its strobe.
- R8: After a repeated start, a matching write header is acknowledged and starts the full two-byte sequence again. addressed_o is 0 until the low byte matches.
- R9: The memory of an earlier selection lasts for only one header byte after a repeated start. Once that header has been used for a write re-match, a later repeated start followed by a read header is not acknowledged.
- R10: irq_o pulses for exactly one cycle, the cycle after each acknowledged address byte. irq_first_o is 1 with that pulse only for a tentative write-header acknowledge, and 0 otherwise.
- R11: ack_o is 0 in any cycle without a byte strobe. It is also 0 for bytes received while addressed (data bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start condition seen (one cycle) |
| rstart_i | input | 1 | Repeated start seen (one cycle) |
| stop_i | input | 1 | Stop condition seen (one cycle) |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte, MSB first on the bus |
| own_addr_i | input | 10 | Configured own ten-bit address |
| ack_o | output | 1 | Acknowledge request for the current byte (combinational) |
| addressed_o | output | 1 | Slave currently selected |
| slave_tx_o | output | 1 | Selected as transmitter |
| irq_o | output | 1 | One-cycle pulse after an acknowledged address byte |
| irq_first_o | output | 1 | With irq_o: the byte was a tentative header, not data |

## Verification
The hardest case to reach from the ports is a read turnaround that should fail because the one-byte memory has been used up. The slave has to be fully addressed first, then get a repeated start with a write re-match header, then a second repeated start with a read header. Directed sequences build this chain and its neighbours: a read header straight after a plain start, and a repeated start that is followed by a mismatch. Random sequences mix events with bytes that are biased toward the own header and the own low byte, so the multi-step paths come up often.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 10;
  localparam int unsigned HI_W     = ADDR_W - BYTE_W;
  localparam int unsigned PREFIX_W = BYTE_W - 1 - HI_W;
  localparam logic [PREFIX_W-1:0] HDR_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // no start seen
    ST_HDR  = 3'd1,  // expecting header byte
    ST_LOW  = 3'd2,  // tentative, expecting low byte
    ST_SEL  = 3'd3,  // addressed, data phase
    ST_SKIP = 3'd4   // not for us, wait for start
  } mstate_e;

  typedef struct packed {
    logic hit;
    logic rd;
  } hdr_res_t;
endpackage

// File: rtl/i2c10_hdr_cmp.sv
module i2c10_hdr_cmp
  import i2c10_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned PW = PREFIX_W,
  parameter logic [PW-1:0] PREFIX = HDR_PREFIX
) (
  input  logic [BW-1:0] byte_i,
  input  logic [AW-1:0] own_addr_i,
  output hdr_res_t      res_o
);
  localparam int unsigned HW = AW - BW;

  logic [BW-2:0] pattern;
  assign pattern   = {PREFIX, own_addr_i[AW-1:BW]};
  assign res_o.hit = (byte_i[BW-1:1] == pattern);
  assign res_o.rd  = byte_i[0];

  logic unused_w;
  assign unused_w = ^HW;
endmodule

// File: rtl/i2c10_low_cmp.sv
module i2c10_low_cmp #(
  parameter int unsigned BW = 8
) (
  input  logic [BW-1:0] byte_i,
  input  logic [BW-1:0] own_lo_i,
  output logic          hit_o
);
  logic [BW-1:0] eq;
  for (genvar i = 0; i < BW; i++) begin : g_bit
    assign eq[i] = ~(byte_i[i] ^ own_lo_i[i]);
  end
  assign hit_o = &eq;
endmodule

// File: rtl/i2c10_seq.sv
module i2c10_seq
  import i2c10_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     rstart_i,
  input  logic     stop_i,
  input  logic     byte_vld_i,
  input  hdr_res_t hdr_i,
  input  logic     low_hit_i,
  output logic     ack_o,
  output logic     addressed_o,
  output logic     slave_tx_o,
  output logic     irq_o,
  output logic     irq_first_o
);
  mstate_e st_q, st_d;
  logic    sel_q, sel_d;
  logic    tx_q, tx_d;
  logic    was_q, was_d;
  logic    ack_d, first_d;

  always_comb begin
    st_d    = st_q;
    sel_d   = sel_q;
    tx_d    = tx_q;
    was_d   = was_q;
    ack_d   = 1'b0;
    first_d = 1'b0;
    if (stop_i) begin
      st_d  = ST_IDLE;
      sel_d = 1'b0;
      tx_d  = 1'b0;
      was_d = 1'b0;
    end else if (start_i) begin
      st_d  = ST_HDR;
      sel_d = 1'b0;
      tx_d  = 1'b0;
      was_d = 1'b0;
    end else if (rstart_i) begin
      // selection stays visible until the next address byte decides
      st_d  = ST_HDR;
      was_d = sel_q;
    end else if (byte_vld_i) begin
      unique case (st_q)
        ST_HDR: begin
          was_d = 1'b0;
          if (hdr_i.hit && !hdr_i.rd) begin
            ack_d   = 1'b1;
            first_d = 1'b1;
            st_d    = ST_LOW;
            sel_d   = 1'b0;
            tx_d    = 1'b0;
          end else if (hdr_i.hit && hdr_i.rd && was_q) begin
            ack_d = 1'b1;
            st_d  = ST_SEL;
            sel_d = 1'b1;
            tx_d  = 1'b1;
          end else begin
            st_d  = ST_SKIP;
            sel_d = 1'b0;
            tx_d  = 1'b0;
          end
        end
        ST_LOW: begin
          if (low_hit_i) begin
            ack_d = 1'b1;
            st_d  = ST_SEL;
            sel_d = 1'b1;
            tx_d  = 1'b0;
          end else begin
            st_d = ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      sel_q       <= 1'b0;
      tx_q        <= 1'b0;
      was_q       <= 1'b0;
      irq_o       <= 1'b0;
      irq_first_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      sel_q       <= sel_d;
      tx_q        <= tx_d;
      was_q       <= was_d;
      irq_o       <= ack_d;
      irq_first_o <= first_d;
    end
  end

  assign ack_o       = ack_d;
  assign addressed_o = sel_q;
  assign slave_tx_o  = tx_q;
endmodule

// File: rtl/i2c10_addr_match.sv
module i2c10_addr_match
  import i2c10_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rstart_i,
  input  logic          stop_i,
  input  logic          byte_vld_i,
  input  logic [BW-1:0] byte_i,
  input  logic [AW-1:0] own_addr_i,
  output logic          ack_o,
  output logic          addressed_o,
  output logic          slave_tx_o,
  output logic          irq_o,
  output logic          irq_first_o
);
  localparam int unsigned PW = BW - 1 - (AW - BW);

  hdr_res_t hdr;
  logic     low_hit;

  i2c10_hdr_cmp #(.BW(BW), .AW(AW), .PW(PW), .PREFIX(HDR_PREFIX)) u_hdr (
    .byte_i    (byte_i),
    .own_addr_i(own_addr_i),
    .res_o     (hdr)
  );

  i2c10_low_cmp #(.BW(BW)) u_low (
    .byte_i  (byte_i),
    .own_lo_i(own_addr_i[BW-1:0]),
    .hit_o   (low_hit)
  );

  i2c10_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rstart_i   (rstart_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .hdr_i      (hdr),
    .low_hit_i  (low_hit),
    .ack_o      (ack_o),
    .addressed_o(addressed_o),
    .slave_tx_o (slave_tx_o),
    .irq_o      (irq_o),
    .irq_first_o(irq_first_o)
  );
endmodule

// File: rtl/i2c10_addr_match_chk.sv
module i2c10_addr_match_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       stop_i,
  input logic       byte_vld_i,
  input logic [7:0] byte_i,
  input logic       ack_o,
  input logic       addressed_o,
  input logic       slave_tx_o,
  input logic       irq_o,
  input logic       irq_first_o
);
  assert_ack_needs_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> byte_vld_i);

  assert_sel_after_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addressed_o) |-> $past(ack_o));

  assert_stop_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i || start_i) |=> (!addressed_o && !slave_tx_o));

  assert_tx_from_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slave_tx_o) |-> ($past(byte_i[0]) && $past(ack_o)));

  assert_tx_implies_sel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_tx_o |-> addressed_o);

  assert_irq_follows_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ack_o));

  assert_first_with_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_first_o |-> (irq_o && !addressed_o));
endmodule

bind i2c10_addr_match i2c10_addr_match_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .stop_i     (stop_i),
  .byte_vld_i (byte_vld_i),
  .byte_i     (byte_i),
  .ack_o      (ack_o),
  .addressed_o(addressed_o),
  .slave_tx_o (slave_tx_o),
  .irq_o      (irq_o),
  .irq_first_o(irq_first_o)
);

// File: tb/sim_i2c10_addr_match.sv
`timescale 1ns/1ps
module sim_i2c10_addr_match;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, rstart_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [9:0] own_addr_i = 10'h000;
  logic       ack_o, addressed_o, slave_tx_o, irq_o, irq_first_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // model: 0 idle, 1 header, 2 low, 3 selected, 4 skip
  int m_st = 0;
  bit m_sel = 0, m_tx = 0, m_was = 0;

  always #5 clk_i = ~clk_i;

  i2c10_addr_match u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rstart_i(rstart_i),
    .stop_i(stop_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .own_addr_i(own_addr_i), .ack_o(ack_o), .addressed_o(addressed_o),
    .slave_tx_o(slave_tx_o), .irq_o(irq_o), .irq_first_o(irq_first_o)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] hdr_of(input logic rd);
    return {5'b11110, own_addr_i[9:8], rd};
  endfunction

  task automatic chk_state(input string req, input bit irq, input bit first);
    chk(addressed_o, m_sel, req);
    chk(slave_tx_o, m_tx, req);
    chk(irq_o, irq, {req, "_R10"});
    chk(irq_first_o, first, {req, "_R10"});
  endtask

  task automatic ev(input int kind);
    @(negedge clk_i);
    start_i  = (kind == 0);
    rstart_i = (kind == 1);
    stop_i   = (kind == 2);
    #1 chk(ack_o, 1'b0, "R11");
    @(negedge clk_i);
    start_i = 0; rstart_i = 0; stop_i = 0;
    if (kind == 1) m_was = m_sel;
    else begin m_sel = 0; m_tx = 0; m_was = 0; end
    m_st = (kind == 2) ? 0 : 1;
    chk_state(kind == 1 ? "R7" : "R4", 0, 0);
  endtask

  task automatic send(input logic [7:0] b, input string req);
    bit exp_ack = 0, first = 0, hm;
    hm = (b[7:1] == {5'b11110, own_addr_i[9:8]});
    case (m_st)
      1: begin
        if (hm && !b[0]) begin
          exp_ack = 1; first = 1; m_st = 2; m_sel = 0; m_tx = 0;
        end else if (hm && b[0] && m_was) begin
          exp_ack = 1; m_st = 3; m_sel = 1; m_tx = 1;
        end else begin
          m_st = 4; m_sel = 0; m_tx = 0;
        end
        m_was = 0;
      end
      2: if (b == own_addr_i[7:0]) begin
           exp_ack = 1; m_st = 3; m_sel = 1; m_tx = 0;
         end else m_st = 4;
      default: ;
    endcase
    @(negedge clk_i);
    byte_vld_i = 1; byte_i = b;
    #1 chk(ack_o, exp_ack, req);
    @(negedge clk_i);
    byte_vld_i = 0;
    chk_state(req, exp_ack, first);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    own_addr_i = 10'h2B5;
    repeat (3) @(negedge clk_i);
    chk(addressed_o, 0, "R4"); chk(slave_tx_o, 0, "R4"); chk(irq_o, 0, "R4");
    rst_ni = 1;
    // R1, R2 write addressing
    ev(0); send(hdr_of(0), "R1"); send(own_addr_i[7:0], "R2");
    send(8'h5A, "R11");
    // R5 read turnaround
    ev(1); send(hdr_of(1), "R5"); send(8'h11, "R11");
    ev(2);
    // R6 read header after plain start
    ev(0); send(hdr_of(1), "R6"); send(own_addr_i[7:0], "R3");
    // R3 low mismatch then ignore
    ev(0); send(hdr_of(0), "R1"); send(own_addr_i[7:0] ^ 8'h01, "R3");
    send(own_addr_i[7:0], "R3"); send(hdr_of(0), "R3");
    // R3 header mismatch (other high bits)
    ev(0); send({5'b11110, ~own_addr_i[9:8], 1'b0}, "R3");
    // R7 Sr with different address drops selection
    ev(0); send(hdr_of(0), "R1"); send(own_addr_i[7:0], "R2");
    ev(1); send(8'hA0, "R7");
    ev(1); send(hdr_of(1), "R6");
    // R8 and R9: Sr + write re-match consumes memory
    ev(0); send(hdr_of(0), "R1"); send(own_addr_i[7:0], "R2");
    ev(1); send(hdr_of(0), "R8");
    ev(1); send(hdr_of(1), "R9");
    // R4 start drops selection
    ev(0); send(hdr_of(0), "R1"); send(own_addr_i[7:0], "R2");
    ev(0); send(hdr_of(1), "R4");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] b;
      op = $urandom_range(0, 99);
      if (op < 10) ev(0);
      else if (op < 28) ev(1);
      else if (op < 36) ev(2);
      else begin
        int k;
        k = $urandom_range(0, 9);
        if (k < 4) b = hdr_of(1'($urandom_range(0, 1)));
        else if (k < 7) b = own_addr_i[7:0];
        else b = 8'($urandom);
        send(b, m_st == 1 ? (b[0] ? "R5" : "R1") : (m_st == 2 ? "R2" : "R3"));
      end
      if (i == 300) own_addr_i = 10'h0F3;
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule